// File: doc/BRIEF.md
# Flash Command Interface Controller

This block decodes the byte-wide command writes a host issues to a flash memory and decides what a host read returns. Each write arrives on a synchronous strobe together with an address and a data byte. Single-write commands change the read source between array data, identifier codes and the status byte. Two-write program and erase sequences are tracked, and their second write launches the external write state machine (WSM) with a one-cycle start pulse that carries the captured address and data.

The WSM reports busy and error conditions back to the block on every clock. Those inputs feed a status byte whose two error flags are sticky: only a clear command resets them. After a program or erase has been launched, the read path shows status until the host selects another source. While the WSM runs, only a status-select or a suspend request is accepted. A suspended erase can be resumed with the confirm code.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset, reads return `arrayData` unchanged, no pulse output is high and both error flags are clear.
- R2: Writing 90h selects identifier reads: `rdAddr0` low returns the manufacturer code parameter (default 89h) and `rdAddr0` high returns the device code parameter (default A2h), whatever `arrayData` holds.
- R3: Writing 70h selects status reads. The status byte holds ready in bit 7, erase-suspended in bit 6, erase-error in bit 5 and program-error in bit 4, and bits 3..0 read as zero.
- R4: A write of 40h or 10h followed by a data write produces `startProg` for exactly one cycle after the second write. `opAddr` and `opData` carry that write's address and data, at most one pulse output is high at a time, and the read path switches to status.
- R5: A write of 20h followed by D0h produces a one-cycle `startErase` pulse carrying the second write's address, and the read path switches to status.
- R6: FFh written as the second write of an erase sequence cancels it: no pulse is produced and reads return array data.
- R7: Any second erase write other than D0h or FFh sets both error flags, produces no pulse and selects status reads.
- R8: In program setup a first FFh is held without starting anything. A second FFh returns reads to the array with no pulse, and any other byte after the held FFh is taken as program data.
- R9: While the WSM is busy, every write except 70h and B0h has no effect on pulses, sequence state or the read source.
- R10: B0h while an erase is busy produces one `suspendReq` pulse and sets the suspended flag. While suspended, D0h produces one `resumeReq` pulse, clears the flag and selects status reads, 90h, FFh, 70h and 50h keep working, and 20h, 40h and 10h are ignored.
- R11: An error reported by the WSM sets the matching flag, which then survives later successful operations and read-source changes until 50h clears both flags. 50h leaves the read source unchanged.
- R12: A code outside the assigned set, written with no sequence open, is ignored and the read source is kept.
- R13: The ready bit is the inverse of `wsmBusy` as sampled one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Host write strobe, one cycle per write |
| wrAddr | input | ADDR_W | Host write address |
| wrData | input | 8 | Host write data or command code |
| rdAddr0 | input | 1 | Lowest read address bit, selects the identifier code |
| arrayData | input | 8 | Byte read from the memory array |
| rdData | output | 8 | Byte returned to the host read |
| wsmBusy | input | 1 | WSM operation in progress |
| wsmProgErr | input | 1 | WSM reports a program failure |
| wsmEraseErr | input | 1 | WSM reports an erase failure |
| startProg | output | 1 | One-cycle program launch |
| startErase | output | 1 | One-cycle erase launch |
| suspendReq | output | 1 | One-cycle erase suspend request |
| resumeReq | output | 1 | One-cycle erase resume request |
| opAddr | output | ADDR_W | Address captured for the launched operation |
| opData | output | 8 | Data captured for the launched operation |

## Verification
The read source and the pulse outputs are registered on the edge that samples a write, so the bench checks both on the falling edge right after that write: `rdData` through the combinational mux from the new source, and the pulse together with `opAddr` and `opData`. A pulse is checked again one falling edge later to confirm that it has dropped. Status flags that depend on the WSM lag by two edges, one for the bench WSM model and one for the sampling register. The bench therefore waits several cycles before judging the ready, suspended and error bits, and it issues busy-phase writes only once that latency has passed.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [1:0] {
    RM_ARRAY  = 2'd0,
    RM_IDENT  = 2'd1,
    RM_STATUS = 2'd2
  } readMode_t;

  typedef enum logic [1:0] {
    SQ_IDLE    = 2'd0,
    SQ_PROG    = 2'd1,
    SQ_PROG_FF = 2'd2,
    SQ_ERASE   = 2'd3
  } seqState_t;

  // Strobes from control to datapath, valid in the cycle of a sampled write.
  typedef struct packed {
    logic goProg;
    logic goErase;
    logic goSuspend;
    logic goResume;
    logic clrErr;
    logic seqErr;
  } ctlStrobe_t;

  localparam logic [7:0] CMD_READ_ARRAY = 8'hFF;
  localparam logic [7:0] CMD_IDENT      = 8'h90;
  localparam logic [7:0] CMD_STATUS     = 8'h70;
  localparam logic [7:0] CMD_CLEAR      = 8'h50;
  localparam logic [7:0] CMD_ERASE      = 8'h20;
  localparam logic [7:0] CMD_CONFIRM    = 8'hD0;
  localparam logic [7:0] CMD_PROG_A     = 8'h40;
  localparam logic [7:0] CMD_PROG_B     = 8'h10;
  localparam logic [7:0] CMD_SUSPEND    = 8'hB0;

  localparam int ST_READY_BIT = 7;
  localparam int ST_SUSP_BIT  = 6;
  localparam int ST_ERASE_BIT = 5;
  localparam int ST_PROG_BIT  = 4;

endpackage

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import flash_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  input  logic       busyQ,
  output readMode_t  readMode,
  output logic       suspended,
  output ctlStrobe_t strb
);

  seqState_t seqState, seqNext;
  readMode_t modeNext;
  logic      eraseRunning;

  always_comb begin
    seqNext  = seqState;
    modeNext = readMode;
    strb     = '0;
    if (wrEn) begin
      if (busyQ) begin
        if (wrData == CMD_STATUS) begin
          modeNext = RM_STATUS;
        end else if (wrData == CMD_SUSPEND && eraseRunning && !suspended) begin
          strb.goSuspend = 1'b1;
        end
      end else begin
        unique case (seqState)
          SQ_IDLE: begin
            unique case (wrData)
              CMD_READ_ARRAY: modeNext = RM_ARRAY;
              CMD_IDENT:      modeNext = RM_IDENT;
              CMD_STATUS:     modeNext = RM_STATUS;
              CMD_CLEAR:      strb.clrErr = 1'b1;
              CMD_PROG_A, CMD_PROG_B: begin
                if (!suspended) seqNext = SQ_PROG;
              end
              CMD_ERASE: begin
                if (!suspended) seqNext = SQ_ERASE;
              end
              CMD_CONFIRM: begin
                if (suspended) begin
                  strb.goResume = 1'b1;
                  modeNext      = RM_STATUS;
                end
              end
              default: ;
            endcase
          end
          SQ_PROG: begin
            if (wrData == CMD_READ_ARRAY) begin
              seqNext = SQ_PROG_FF;
            end else begin
              strb.goProg = 1'b1;
              modeNext    = RM_STATUS;
              seqNext     = SQ_IDLE;
            end
          end
          SQ_PROG_FF: begin
            seqNext = SQ_IDLE;
            if (wrData == CMD_READ_ARRAY) begin
              modeNext = RM_ARRAY;
            end else begin
              strb.goProg = 1'b1;
              modeNext    = RM_STATUS;
            end
          end
          SQ_ERASE: begin
            seqNext = SQ_IDLE;
            if (wrData == CMD_CONFIRM) begin
              strb.goErase = 1'b1;
              modeNext     = RM_STATUS;
            end else if (wrData == CMD_READ_ARRAY) begin
              modeNext = RM_ARRAY;
            end else begin
              strb.seqErr = 1'b1;
              modeNext    = RM_STATUS;
            end
          end
          default: seqNext = SQ_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seqState     <= SQ_IDLE;
      readMode     <= RM_ARRAY;
      suspended    <= 1'b0;
      eraseRunning <= 1'b0;
    end else begin
      seqState <= seqNext;
      readMode <= modeNext;
      if (strb.goSuspend)     suspended <= 1'b1;
      else if (strb.goResume) suspended <= 1'b0;
      if (strb.goErase)       eraseRunning <= 1'b1;
      else if (strb.goProg)   eraseRunning <= 1'b0;
    end
  end

endmodule

// File: rtl/flash_cmd_datapath.sv
module flash_cmd_datapath
  import flash_cmd_pkg::*;
#(
  parameter int         ADDR_W   = 10,
  parameter logic [7:0] MFR_CODE = 8'h89,
  parameter logic [7:0] DEV_CODE = 8'hA2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic              rdAddr0,
  input  logic [7:0]        arrayData,
  input  readMode_t         readMode,
  input  logic              suspended,
  input  logic              wsmBusy,
  input  logic              wsmProgErr,
  input  logic              wsmEraseErr,
  output logic              busyQ,
  output logic              progErrQ,
  output logic              eraseErrQ,
  output logic [7:0]        rdData,
  output logic              startProg,
  output logic              startErase,
  output logic              suspendReq,
  output logic              resumeReq,
  output logic [ADDR_W-1:0] opAddr,
  output logic [7:0]        opData
);

  logic [7:0] statusByte;
  logic       progErrNext, eraseErrNext;

  // Set sources win over the clear strobe.
  assign progErrNext  = wsmProgErr  | strb.seqErr | (progErrQ  & ~strb.clrErr);
  assign eraseErrNext = wsmEraseErr | strb.seqErr | (eraseErrQ & ~strb.clrErr);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ      <= 1'b0;
      progErrQ   <= 1'b0;
      eraseErrQ  <= 1'b0;
      startProg  <= 1'b0;
      startErase <= 1'b0;
      suspendReq <= 1'b0;
      resumeReq  <= 1'b0;
      opAddr     <= '0;
      opData     <= '0;
    end else begin
      busyQ      <= wsmBusy;
      progErrQ   <= progErrNext;
      eraseErrQ  <= eraseErrNext;
      startProg  <= strb.goProg;
      startErase <= strb.goErase;
      suspendReq <= strb.goSuspend;
      resumeReq  <= strb.goResume;
      if (strb.goProg || strb.goErase) begin
        opAddr <= wrAddr;
        opData <= wrData;
      end
    end
  end

  always_comb begin
    statusByte               = '0;
    statusByte[ST_READY_BIT] = ~busyQ;
    statusByte[ST_SUSP_BIT]  = suspended;
    statusByte[ST_ERASE_BIT] = eraseErrQ;
    statusByte[ST_PROG_BIT]  = progErrQ;
  end

  always_comb begin
    unique case (readMode)
      RM_IDENT:  rdData = rdAddr0 ? DEV_CODE : MFR_CODE;
      RM_STATUS: rdData = statusByte;
      default:   rdData = arrayData;
    endcase
  end

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int         ADDR_W   = 10,
  parameter logic [7:0] MFR_CODE = 8'h89,
  parameter logic [7:0] DEV_CODE = 8'hA2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic              rdAddr0,
  input  logic [7:0]        arrayData,
  output logic [7:0]        rdData,
  input  logic              wsmBusy,
  input  logic              wsmProgErr,
  input  logic              wsmEraseErr,
  output logic              startProg,
  output logic              startErase,
  output logic              suspendReq,
  output logic              resumeReq,
  output logic [ADDR_W-1:0] opAddr,
  output logic [7:0]        opData
);

  ctlStrobe_t strb;
  readMode_t  readMode;
  logic       suspended;
  logic       busyQ;
  logic       progErrQ;
  logic       eraseErrQ;

  flash_cmd_fsm u_fsm (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .wrData    (wrData),
    .busyQ     (busyQ),
    .readMode  (readMode),
    .suspended (suspended),
    .strb      (strb)
  );

  flash_cmd_datapath #(
    .ADDR_W   (ADDR_W),
    .MFR_CODE (MFR_CODE),
    .DEV_CODE (DEV_CODE)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .wrAddr      (wrAddr),
    .wrData      (wrData),
    .rdAddr0     (rdAddr0),
    .arrayData   (arrayData),
    .readMode    (readMode),
    .suspended   (suspended),
    .wsmBusy     (wsmBusy),
    .wsmProgErr  (wsmProgErr),
    .wsmEraseErr (wsmEraseErr),
    .busyQ       (busyQ),
    .progErrQ    (progErrQ),
    .eraseErrQ   (eraseErrQ),
    .rdData      (rdData),
    .startProg   (startProg),
    .startErase  (startErase),
    .suspendReq  (suspendReq),
    .resumeReq   (resumeReq),
    .opAddr      (opAddr),
    .opData      (opData)
  );

endmodule

// File: rtl/flash_cmd_ctrl_chk.sv
module flash_cmd_ctrl_chk
  import flash_cmd_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic [7:0] wrData,
  input logic       startProg,
  input logic       startErase,
  input logic       suspendReq,
  input logic       resumeReq,
  input logic       busyQ,
  input logic       progErrQ,
  input logic       eraseErrQ,
  input readMode_t  readMode,
  input ctlStrobe_t strb
);

  // R4
  pulses_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({startProg, startErase, suspendReq, resumeReq}));

  // R4
  prog_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    startProg |=> !startProg);

  // R9
  busy_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && busyQ) |=> (!startProg && !startErase && !resumeReq));

  // R11
  sticky_prog_chk: assert property (@(posedge clk) disable iff (!rstN)
    (progErrQ && !(wrEn && wrData == CMD_CLEAR)) |=> progErrQ);

  // R11
  sticky_erase_chk: assert property (@(posedge clk) disable iff (!rstN)
    (eraseErrQ && !(wrEn && wrData == CMD_CLEAR)) |=> eraseErrQ);

  // R7
  seq_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.seqErr |=> (progErrQ && eraseErrQ && !startErase));

  // R3
  status_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrData == CMD_STATUS) |=> readMode == RM_STATUS);

endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .wrEn       (wrEn),
  .wrData     (wrData),
  .startProg  (startProg),
  .startErase (startErase),
  .suspendReq (suspendReq),
  .resumeReq  (resumeReq),
  .busyQ      (busyQ),
  .progErrQ   (progErrQ),
  .eraseErrQ  (eraseErrQ),
  .readMode   (readMode),
  .strb       (strb)
);

// File: tb/sim_flash_cmd_ctrl.sv
`timescale 1ns/1ps
module sim_flash_cmd_ctrl;

  localparam int         ADDR_W = 10;
  localparam logic [7:0] MFR    = 8'h89;
  localparam logic [7:0] DEV    = 8'hA2;
  localparam int         OPLEN  = 12;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              wrEn = 1'b0;
  logic [ADDR_W-1:0] wrAddr = '0;
  logic [7:0]        wrData = '0;
  logic              rdAddr0 = 1'b0;
  logic [7:0]        arrayData = '0;
  logic [7:0]        rdData;
  logic              wsmBusy, wsmProgErr, wsmEraseErr;
  logic              startProg, startErase, suspendReq, resumeReq;
  logic [ADDR_W-1:0] opAddr;
  logic [7:0]        opData;

  int   checks = 0;
  int   failures = 0;
  logic failNext = 1'b0;
  logic kindErase;
  int   cnt;
  logic done = 1'b0;

  always #10 clk = ~clk;

  flash_cmd_ctrl #(.ADDR_W(ADDR_W), .MFR_CODE(MFR), .DEV_CODE(DEV)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr0(rdAddr0), .arrayData(arrayData), .rdData(rdData),
    .wsmBusy(wsmBusy), .wsmProgErr(wsmProgErr), .wsmEraseErr(wsmEraseErr),
    .startProg(startProg), .startErase(startErase), .suspendReq(suspendReq),
    .resumeReq(resumeReq), .opAddr(opAddr), .opData(opData)
  );

  // Behavioural write state machine.
  always @(posedge clk) begin
    if (!rstN) begin
      wsmBusy <= 1'b0; wsmProgErr <= 1'b0; wsmEraseErr <= 1'b0;
      kindErase <= 1'b0; cnt <= 0;
    end else begin
      wsmProgErr  <= 1'b0;
      wsmEraseErr <= 1'b0;
      if (startProg || startErase || resumeReq) begin
        wsmBusy <= 1'b1;
        cnt     <= OPLEN;
        if (startProg)  kindErase <= 1'b0;
        if (startErase) kindErase <= 1'b1;
      end else if (suspendReq) begin
        wsmBusy <= 1'b0;
      end else if (wsmBusy) begin
        if (cnt == 0) begin
          wsmBusy <= 1'b0;
          if (kindErase) wsmEraseErr <= failNext;
          else           wsmProgErr  <= failNext;
        end else begin
          cnt <= cnt - 1;
        end
      end
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  function automatic logic [7:0] pulses();
    return {4'b0, startProg, startErase, suspendReq, resumeReq};
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic readChk(input string req, input logic a0, input logic [7:0] arr,
                         input logic [7:0] exp);
    rdAddr0 = a0; arrayData = arr; #1;
    chk(req, rdData, exp);
  endtask

  function automatic logic isValid(input logic [7:0] c);
    return (c == 8'hFF || c == 8'h90 || c == 8'h70 || c == 8'h50 ||
            c == 8'h40 || c == 8'h10 || c == 8'h20);
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(1);

    // R1: reset state
    chk("R1 pulses", pulses(), 8'h00);
    for (int v = 0; v < 256; v++) readChk("R1 array", v[0], v[7:0], v[7:0]);
    wr(0, 8'h70);
    readChk("R1 flags clear", 1'b0, 8'h00, 8'h80);
    wr(0, 8'hFF);

    // R12: unassigned codes in idle keep array mode
    for (int c = 0; c < 256; c++) begin
      if (!isValid(c[7:0])) begin
        wr(ADDR_W'(c), c[7:0]);
        readChk("R12 ignored", 1'b1, ~c[7:0], ~c[7:0]);
        chk("R12 no pulse", pulses(), 8'h00);
      end
    end

    // R2: identifier codes on address bit 0
    wr(0, 8'h90);
    for (int v = 0; v < 256; v += 17) begin
      readChk("R2 mfr", 1'b0, v[7:0], MFR);
      readChk("R2 dev", 1'b1, v[7:0], DEV);
    end
    wr(0, 8'h21);
    readChk("R12 ident kept", 1'b1, 8'h00, DEV);

    // R3: status for any address, layout 80h when idle and clean
    wr(0, 8'h70);
    for (int v = 0; v < 256; v += 51) begin
      readChk("R3 status", 1'b0, v[7:0], 8'h80);
      readChk("R3 status", 1'b1, v[7:0], 8'h80);
    end

    // R4: program with 40h
    wr(0, 8'hFF);
    wr(0, 8'h40);
    wr(10'h155, 8'hA7);
    chk("R4 pulse", pulses(), 8'h08);
    chk("R4 opAddr", opAddr[7:0], 8'h55);
    chk("R4 opAddr hi", {6'b0, opAddr[9:8]}, 8'h01);
    chk("R4 opData", opData, 8'hA7);
    readChk("R4 status sel", 1'b0, 8'h33, 8'h80);
    idle(1);
    chk("R4 single", pulses(), 8'h00);
    idle(2);
    // R13: ready low while busy
    readChk("R13 busy", 1'b0, 8'h33, 8'h00);
    // R9: writes while busy
    wr(0, 8'hFF);
    readChk("R9 FF ignored", 1'b0, 8'h33, 8'h00);
    wr(0, 8'h40);
    chk("R9 no pulse", pulses(), 8'h00);
    wr(0, 8'h12);
    chk("R9 no pulse", pulses(), 8'h00);
    wr(0, 8'h90);
    readChk("R9 90 ignored", 1'b1, 8'h33, 8'h00);
    idle(20);
    readChk("R13 ready", 1'b0, 8'h33, 8'h80);
    chk("R9 no late pulse", pulses(), 8'h00);

    // R4: program with 10h alias
    wr(0, 8'h10);
    wr(10'h0F0, 8'h3C);
    chk("R4 alias pulse", pulses(), 8'h08);
    chk("R4 alias data", opData, 8'h3C);
    chk("R4 alias addr", opAddr[7:0], 8'hF0);
    idle(20);

    // R11: sticky program error
    failNext = 1'b1;
    wr(0, 8'h40); wr(1, 8'h11);
    idle(20);
    readChk("R11 prog err", 1'b0, 8'h00, 8'h90);
    failNext = 1'b0;
    wr(0, 8'h40); wr(2, 8'h22);
    idle(20);
    readChk("R11 err kept", 1'b0, 8'h00, 8'h90);
    wr(0, 8'hFF);
    readChk("R11 array", 1'b0, 8'h6B, 8'h6B);
    wr(0, 8'h70);
    readChk("R11 still set", 1'b0, 8'h6B, 8'h90);
    wr(0, 8'h50);
    readChk("R11 cleared", 1'b0, 8'h6B, 8'h80);

    // R5, R10: erase, suspend, resume
    wr(0, 8'h20);
    wr(10'h2AA, 8'hD0);
    chk("R5 pulse", pulses(), 8'h04);
    chk("R5 opAddr", opAddr[7:0], 8'hAA);
    readChk("R5 status sel", 1'b0, 8'h44, 8'h80);
    idle(3);
    readChk("R5 busy", 1'b0, 8'h44, 8'h00);
    wr(0, 8'hB0);
    chk("R10 suspend", pulses(), 8'h02);
    idle(3);
    readChk("R10 suspended", 1'b0, 8'h44, 8'hC0);
    wr(0, 8'h40);
    wr(0, 8'h55);
    chk("R10 prog blocked", pulses(), 8'h00);
    wr(0, 8'hFF);
    readChk("R10 array in suspend", 1'b0, 8'h5E, 8'h5E);
    wr(0, 8'hD0);
    chk("R10 resume", pulses(), 8'h01);
    readChk("R10 resume status", 1'b0, 8'h11, 8'h80);
    idle(3);
    readChk("R10 running", 1'b0, 8'h11, 8'h00);
    idle(20);
    readChk("R10 done", 1'b0, 8'h11, 8'h80);

    // R11: erase error from WSM
    failNext = 1'b1;
    wr(0, 8'h20); wr(5, 8'hD0);
    idle(20);
    failNext = 1'b0;
    readChk("R11 erase err", 1'b0, 8'h00, 8'hA0);
    wr(0, 8'h50);
    readChk("R11 erase clr", 1'b0, 8'h00, 8'h80);

    // R7: bad erase confirm
    wr(0, 8'h20);
    wr(0, 8'h33);
    chk("R7 no pulse", pulses(), 8'h00);
    readChk("R7 both errs", 1'b0, 8'h00, 8'hB0);
    wr(0, 8'h50);
    readChk("R7 cleared", 1'b0, 8'h00, 8'h80);

    // R6: erase cancelled by FFh
    wr(0, 8'h20);
    wr(0, 8'hFF);
    chk("R6 no pulse", pulses(), 8'h00);
    readChk("R6 array", 1'b1, 8'hC3, 8'hC3);
    wr(0, 8'h70);
    readChk("R6 no error", 1'b0, 8'hC3, 8'h80);

    // R8: program setup exit rules
    wr(0, 8'h40);
    wr(0, 8'hFF);
    chk("R8 first FF", pulses(), 8'h00);
    readChk("R8 mode held", 1'b0, 8'h2D, 8'h80);
    wr(0, 8'hFF);
    chk("R8 second FF", pulses(), 8'h00);
    readChk("R8 array", 1'b0, 8'h2D, 8'h2D);
    wr(0, 8'h10);
    wr(0, 8'hFF);
    wr(10'h077, 8'h5C);
    chk("R8 data after FF", pulses(), 8'h08);
    chk("R8 data", opData, 8'h5C);
    chk("R8 addr", opAddr[7:0], 8'h77);
    idle(20);
    readChk("R8 done", 1'b0, 8'h00, 8'h80);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule